// File: doc/BRIEF.md
# Block-Frame Parallel Viterbi Word Scorer

This block scores a set of left-to-right hidden Markov word models against one utterance and reports which model fits best. For every model the host loads the log self-transition and log forward-transition values, then streams log output probabilities. Each frame supplies one word per state. The words arrive in blocks of `BLOCK_FRAMES` frames. A block is first gathered into a small buffer. The scorer then runs one recursion step per cycle for the frames of that block, and in each step it updates all state scores in parallel. So the output-probability phase for a block comes first and its partial-probability phase follows, rather than the two alternating frame by frame.

Each recursion step, for every state, takes the better of two candidates: staying in the state, or arriving from the state on its left. It then adds the log output probability for that frame and state. All arithmetic is signed fixed point and saturates at both ends, so the most negative value acts as minus infinity. When the last block of a model has been processed, the score of the final state becomes that model's final score. That score is compared with the best score seen so far in the utterance. An end flag closes the utterance, and the scorer answers with a one-cycle done pulse, the index of the winning model and its score.

Top module: `bfp_viterbi_scorer`

## Requirements
- R1: After reset, `inReady` is 1, `done` is 0, and `winIdx` and `winScore` are 0.
- R2: `modelStart`, accepted while `inReady` is 1, sets the score of state 0 to 0 and the score of every other state to the most negative value (-2^(W-1)).
- R3: Observation words are accepted while `inReady` is 1, ordered frame by frame and, within a frame, state 0 first up to state N-1. After the M*N-th word of a block, `inReady` is 0 for exactly M cycles. If `obsLast` accompanied that word, `inReady` is 0 for M+1 cycles.
- R4: Each recursion step sets score_j = sat(max(sat(score_j + self_j), sat(score_{j-1} + fwd_{j-1})) + obs_j). Here `selfTrans[j*W +: W]` is self_j and `nextTrans[j*W +: W]` is the log transition from state j to state j+1.
- R5: State 0 has no left neighbour. Its forward candidate is the most negative value, so a path can only start in state 0.
- R6: Every addition saturates to the range [-2^(W-1), 2^(W-1)-1] instead of wrapping.
- R7: After the block marked by `obsLast`, the final score of the model is the score of state N-1. `winScore` reports the best final score of the utterance.
- R8: Models are indexed 0, 1, 2, ... in the order they are started within an utterance. `winIdx` is the index of the model with the highest final score, and a tie keeps the lower index.
- R9: `endFlag` makes `done` high for exactly one cycle once no block is pending. An `endFlag` that arrives during an update phase is held, and the done pulse that follows includes the model being finished.
- R10: After a done pulse, the next utterance starts again at model index 0 with no memory of earlier best scores. `winIdx` and `winScore` hold their values until that utterance's first `modelStart`.
- R11: Transition values are sampled only at `modelStart`. Changes on `selfTrans` and `nextTrans` afterwards have no effect on the model's score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modelStart | input | 1 | Begin a new model; samples the transition values |
| selfTrans | input | N*W | Log self-transition per state |
| nextTrans | input | (N-1)*W | Log transition from state j to j+1 |
| obsValid | input | 1 | Observation word is valid |
| obsLast | input | 1 | Marks the last word of the model's last block |
| obsData | input | W | Log output probability, signed |
| endFlag | input | 1 | End of utterance request |
| inReady | output | 1 | Scorer accepts `modelStart` and words |
| done | output | 1 | One-cycle result pulse |
| winIdx | output | MODEL_W | Index of the best model |
| winScore | output | W | Final score of the best model |

## Verification
The end of an utterance can coincide with the final update of the last model. The bench raises `endFlag` in the cycle right after the last word of a model. At that point the scorer is still stepping through the block and has not yet committed the model's final score. The last model is made the winner in that case, so a done pulse that ignored the pending commit would report the wrong index and score. The bench judges the result against its own recursion model, and also checks that the pulse lasts a single cycle.

// File: rtl/vitPkg.sv
package vitPkg;

  typedef enum logic [1:0] {
    S_LOAD   = 2'd0,
    S_UPD    = 2'd1,
    S_COMMIT = 2'd2
  } phase_t;

  typedef struct packed {
    logic initScores;
    logic writeObs;
    logic updStep;
    logic commit;
  } ctrlStrobes_t;

endpackage

// File: rtl/vitCtrl.sv
module vitCtrl #(
  parameter int N       = 4,
  parameter int M       = 4,
  parameter int MODEL_W = 5,
  parameter int FR_W    = 2,
  parameter int ST_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modelStart,
  input  logic                  obsValid,
  input  logic                  obsLast,
  input  logic                  endFlag,
  output vitPkg::ctrlStrobes_t  stb,
  output logic [FR_W-1:0]       wrFrame,
  output logic [ST_W-1:0]       wrState,
  output logic [FR_W-1:0]       updFrame,
  output logic [MODEL_W-1:0]    modelIdx,
  output logic                  inReady,
  output logic                  done
);
  import vitPkg::*;

  localparam logic [FR_W-1:0] LAST_FR = FR_W'(M - 1);
  localparam logic [ST_W-1:0] LAST_ST = ST_W'(N - 1);

  phase_t state;
  logic   lastBlk;
  logic   pendQ;
  logic   doneQ;
  logic   finishNow;

  assign inReady   = (state == S_LOAD);
  assign done      = doneQ;
  assign finishNow = (state == S_LOAD) && (pendQ || endFlag) && !obsValid && !modelStart;

  always_comb begin
    stb = '0;
    case (state)
      S_LOAD: begin
        stb.initScores = modelStart;
        stb.writeObs   = obsValid && !modelStart;
      end
      S_UPD:    stb.updStep = 1'b1;
      S_COMMIT: stb.commit  = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_LOAD;
      wrFrame  <= '0;
      wrState  <= '0;
      updFrame <= '0;
      modelIdx <= '0;
      lastBlk  <= 1'b0;
      pendQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_LOAD: begin
          if (finishNow) begin
            doneQ    <= 1'b1;
            pendQ    <= 1'b0;
            modelIdx <= '0;
          end else begin
            pendQ <= pendQ || endFlag;
          end
          if (stb.initScores) begin
            wrFrame <= '0;
            wrState <= '0;
          end else if (stb.writeObs) begin
            if (wrState == LAST_ST) begin
              wrState <= '0;
              if (wrFrame == LAST_FR) begin
                wrFrame  <= '0;
                updFrame <= '0;
                lastBlk  <= obsLast;
                state    <= S_UPD;
              end else begin
                wrFrame <= wrFrame + 1'b1;
              end
            end else begin
              wrState <= wrState + 1'b1;
            end
          end
        end
        S_UPD: begin
          pendQ    <= pendQ || endFlag;
          updFrame <= updFrame + 1'b1;
          if (updFrame == LAST_FR) begin
            updFrame <= '0;
            state    <= lastBlk ? S_COMMIT : S_LOAD;
          end
        end
        S_COMMIT: begin
          pendQ    <= pendQ || endFlag;
          modelIdx <= modelIdx + 1'b1;
          state    <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  // R9: a result pulse lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: a result is only issued from the idle loading phase
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(state) == S_LOAD);

  // R3: an update phase runs through all frames of the block
  p_update_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UPD && updFrame != LAST_FR) |=> state == S_UPD);

  // R8: each committed model advances the model index by one
  p_model_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> modelIdx == $past(modelIdx) + 1'b1);

endmodule

// File: rtl/vitDatapath.sv
module vitDatapath #(
  parameter int W       = 16,
  parameter int N       = 4,
  parameter int M       = 4,
  parameter int MODEL_W = 5,
  parameter int FR_W    = 2,
  parameter int ST_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  vitPkg::ctrlStrobes_t       stb,
  input  logic [FR_W-1:0]            wrFrame,
  input  logic [ST_W-1:0]            wrState,
  input  logic [FR_W-1:0]            updFrame,
  input  logic [MODEL_W-1:0]         modelIdx,
  input  logic [N*W-1:0]             selfTrans,
  input  logic [(N-1)*W-1:0]         nextTrans,
  input  logic signed [W-1:0]        obsData,
  output logic [MODEL_W-1:0]         winIdx,
  output logic signed [W-1:0]        winScore
);

  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  function automatic logic signed [W-1:0] satAdd(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
    logic signed [W:0] s;
    s = {a[W-1], a} + {b[W-1], b};
    if (s[W] == 1'b0 && s[W-1] == 1'b1)      satAdd = MAXV;
    else if (s[W] == 1'b1 && s[W-1] == 1'b0) satAdd = MINV;
    else                                     satAdd = s[W-1:0];
  endfunction

  logic signed [W-1:0] scoreQ   [N];
  logic signed [W-1:0] scoreNxt [N];
  logic signed [W-1:0] selfQ    [N];
  logic signed [W-1:0] nextQ    [N-1];
  logic signed [W-1:0] obsBuf   [M][N];
  logic                bestValid;
  logic signed [W-1:0] bestScore;
  logic [MODEL_W-1:0]  bestIdx;
  logic signed [W-1:0] finalScore;

  assign finalScore = scoreQ[N-1];
  assign winIdx     = bestIdx;
  assign winScore   = bestScore;

  for (genvar j = 0; j < N; j++) begin : g_state
    logic signed [W-1:0] stayC;
    logic signed [W-1:0] moveC;
    logic signed [W-1:0] bestC;

    assign stayC = satAdd(scoreQ[j], selfQ[j]);
    if (j == 0) begin : g_first
      assign moveC = MINV;
    end else begin : g_rest
      assign moveC = satAdd(scoreQ[j-1], nextQ[j-1]);
    end
    assign bestC       = (stayC > moveC) ? stayC : moveC;
    assign scoreNxt[j] = satAdd(bestC, obsBuf[updFrame][j]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scoreQ[j] <= (j == 0) ? '0 : MINV;
        selfQ[j]  <= '0;
      end else if (stb.initScores) begin
        scoreQ[j] <= (j == 0) ? '0 : MINV;
        selfQ[j]  <= selfTrans[j*W +: W];
      end else if (stb.updStep) begin
        scoreQ[j] <= scoreNxt[j];
      end
    end

    for (genvar f = 0; f < M; f++) begin : g_buf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          obsBuf[f][j] <= '0;
        end else if (stb.writeObs && wrFrame == FR_W'(f) && wrState == ST_W'(j)) begin
          obsBuf[f][j] <= obsData;
        end
      end
    end

    // R6: non-negative operands never produce a smaller result (no wrap)
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
      (stb.updStep && scoreQ[j] >= 0 && selfQ[j] >= 0 && obsBuf[updFrame][j] >= 0)
      |=> scoreQ[j] >= $past(scoreQ[j]));
  end

  for (genvar k = 0; k < N-1; k++) begin : g_fwd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               nextQ[k] <= '0;
      else if (stb.initScores) nextQ[k] <= nextTrans[k*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestValid <= 1'b0;
      bestScore <= '0;
      bestIdx   <= '0;
    end else if (stb.initScores && modelIdx == '0) begin
      bestValid <= 1'b0;
    end else if (stb.commit) begin
      if (!bestValid || finalScore > bestScore) begin
        bestScore <= finalScore;
        bestIdx   <= modelIdx;
      end
      bestValid <= 1'b1;
    end
  end

  // R2: a model start leaves state 0 at zero and the last state unreachable
  p_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.initScores |=> (scoreQ[0] == '0 && scoreQ[N-1] == MINV));

  // R8: an equal later score keeps the earlier winner
  p_tie_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && bestValid && finalScore == bestScore) |=> $stable(bestIdx));

endmodule

// File: rtl/bfp_viterbi_scorer.sv
module bfp_viterbi_scorer #(
  parameter int W            = 16,
  parameter int NUM_STATES   = 4,
  parameter int BLOCK_FRAMES = 4,
  parameter int MAX_MODELS   = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                modelStart,
  input  logic [NUM_STATES*W-1:0]             selfTrans,
  input  logic [(NUM_STATES-1)*W-1:0]         nextTrans,
  input  logic                                obsValid,
  input  logic                                obsLast,
  input  logic signed [W-1:0]                 obsData,
  input  logic                                endFlag,
  output logic                                inReady,
  output logic                                done,
  output logic [$clog2(MAX_MODELS)-1:0]       winIdx,
  output logic signed [W-1:0]                 winScore
);

  localparam int MODEL_W = $clog2(MAX_MODELS);
  localparam int FR_W    = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;
  localparam int ST_W    = $clog2(NUM_STATES);

  vitPkg::ctrlStrobes_t stb;
  logic [FR_W-1:0]      wrFrame;
  logic [ST_W-1:0]      wrState;
  logic [FR_W-1:0]      updFrame;
  logic [MODEL_W-1:0]   modelIdx;

  vitCtrl #(
    .N(NUM_STATES), .M(BLOCK_FRAMES), .MODEL_W(MODEL_W), .FR_W(FR_W), .ST_W(ST_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modelStart(modelStart), .obsValid(obsValid),
    .obsLast(obsLast), .endFlag(endFlag), .stb(stb), .wrFrame(wrFrame),
    .wrState(wrState), .updFrame(updFrame), .modelIdx(modelIdx),
    .inReady(inReady), .done(done)
  );

  vitDatapath #(
    .W(W), .N(NUM_STATES), .M(BLOCK_FRAMES), .MODEL_W(MODEL_W), .FR_W(FR_W), .ST_W(ST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrFrame(wrFrame), .wrState(wrState),
    .updFrame(updFrame), .modelIdx(modelIdx), .selfTrans(selfTrans),
    .nextTrans(nextTrans), .obsData(obsData), .winIdx(winIdx), .winScore(winScore)
  );

endmodule

// File: tb/sim_bfp_viterbi_scorer.sv
module sim_bfp_viterbi_scorer;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int MW = 5;
  localparam int MAXFR = 3 * M;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 modelStart, obsValid, obsLast, endFlag;
  logic [N*W-1:0]       selfTrans;
  logic [(N-1)*W-1:0]   nextTrans;
  logic signed [W-1:0]  obsData;
  logic                 inReady, done;
  logic [MW-1:0]        winIdx;
  logic signed [W-1:0]  winScore;

  int checks = 0;
  int errors = 0;

  int obsMem  [8][MAXFR][N];
  int selfMem [8][N];
  int nextMem [8][N-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  bfp_viterbi_scorer #(.W(W), .NUM_STATES(N), .BLOCK_FRAMES(M), .MAX_MODELS(32)) u0 (
    .clk(clk), .rstN(rstN), .modelStart(modelStart), .selfTrans(selfTrans),
    .nextTrans(nextTrans), .obsValid(obsValid), .obsLast(obsLast), .obsData(obsData),
    .endFlag(endFlag), .inReady(inReady), .done(done), .winIdx(winIdx), .winScore(winScore)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int refFinal(input int m, input int nFr);
    int sc [N];
    int nw [N];
    for (int j = 0; j < N; j++) sc[j] = (j == 0) ? 0 : -32768;
    for (int t = 0; t < nFr; t++) begin
      for (int j = 0; j < N; j++) begin
        int stay, mv;
        stay = sat(sc[j] + selfMem[m][j]);
        mv   = (j == 0) ? -32768 : sat(sc[j-1] + nextMem[m][j-1]);
        nw[j] = sat(((stay > mv) ? stay : mv) + obsMem[m][t][j]);
      end
      for (int j = 0; j < N; j++) sc[j] = nw[j];
    end
    return sc[N-1];
  endfunction

  task automatic fillRandom(input int nMod);
    for (int m = 0; m < nMod; m++) begin
      for (int j = 0; j < N; j++) selfMem[m][j] = -int'($urandom_range(400, 0));
      for (int j = 0; j < N-1; j++) nextMem[m][j] = -int'($urandom_range(400, 0));
      for (int t = 0; t < MAXFR; t++)
        for (int j = 0; j < N; j++) obsMem[m][t][j] = -int'($urandom_range(1500, 0));
    end
  endtask

  task automatic fillConst(input int m, input int obsV, input int selfV, input int nextV);
    for (int j = 0; j < N; j++) selfMem[m][j] = selfV;
    for (int j = 0; j < N-1; j++) nextMem[m][j] = nextV;
    for (int t = 0; t < MAXFR; t++)
      for (int j = 0; j < N; j++) obsMem[m][t][j] = obsV;
  endtask

  task automatic startModel(input int m);
    while (!inReady) @(negedge clk);
    for (int j = 0; j < N; j++) selfTrans[j*W +: W] = W'(selfMem[m][j]);
    for (int j = 0; j < N-1; j++) nextTrans[j*W +: W] = W'(nextMem[m][j]);
    modelStart = 1'b1;
    @(negedge clk);
    modelStart = 1'b0;
    // R11: port values after the start must not matter
    selfTrans = {N{16'h7F00}};
    nextTrans = {(N-1){16'h7F00}};
  endtask

  task automatic putWord(input int v, input bit last);
    while (!inReady) @(negedge clk);
    obsValid = 1'b1;
    obsData  = W'(v);
    obsLast  = last;
    @(negedge clk);
    obsValid = 1'b0;
    obsLast  = 1'b0;
  endtask

  task automatic runUtt(input int nMod, input int nBlk, input bit endEarly,
                        input bit chkReady, input string tag);
    int expI, expS, fin, cnt, k;
    bit last;
    for (int m = 0; m < nMod; m++) begin
      startModel(m);
      for (int b = 0; b < nBlk; b++)
        for (int f = 0; f < M; f++)
          for (int s = 0; s < N; s++) begin
            last = (b == nBlk-1) && (f == M-1) && (s == N-1);
            putWord(obsMem[m][b*M+f][s], last);
            if (f == M-1 && s == N-1) begin
              if (endEarly && last && m == nMod-1) begin
                endFlag = 1'b1;
                @(negedge clk);
                endFlag = 1'b0;
              end else if (chkReady && m == 0) begin
                cnt = 0;
                while (!inReady) begin cnt++; @(negedge clk); end
                check(cnt == (last ? M+1 : M), "R3 busy cycles", cnt, last ? M+1 : M);
              end
            end
          end
    end
    expI = 0; expS = 0;
    for (int m = 0; m < nMod; m++) begin
      fin = refFinal(m, nBlk*M);
      if (m == 0 || fin > expS) begin expS = fin; expI = m; end
    end
    if (!endEarly) begin
      while (!inReady) @(negedge clk);
      endFlag = 1'b1;
      @(negedge clk);
      endFlag = 1'b0;
    end
    k = 0;
    while (!done && k < 50) begin @(negedge clk); k++; end
    check(done == 1'b1, {"R9 done seen ", tag}, int'(done), 1);
    check(int'(winIdx) == expI, {"R8 winner ", tag}, int'(winIdx), expI);
    check(int'(winScore) == expS, {"R4 R7 score ", tag}, int'(winScore), expS);
    @(negedge clk);
    check(done == 1'b0, {"R9 single pulse ", tag}, int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; modelStart = 0; obsValid = 0; obsLast = 0; endFlag = 0;
    obsData = '0; selfTrans = '0; nextTrans = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(winIdx == '0, "R1 winIdx", int'(winIdx), 0);
    check(winScore == '0, "R1 winScore", int'(winScore), 0);

    // random utterances, R11 scrambling applied in every start
    for (int u = 0; u < 6; u++) begin
      int nMod, nBlk;
      nMod = int'($urandom_range(6, 1));
      nBlk = int'($urandom_range(3, 1));
      fillRandom(nMod);
      runUtt(nMod, nBlk, u == 2, u == 0, "R11 random");
    end

    // R8 tie: models 1 and 2 identical, both beat model 0
    fillRandom(3);
    fillConst(0, -3000, -400, -400);
    selfMem[2] = selfMem[1]; nextMem[2] = nextMem[1]; obsMem[2] = obsMem[1];
    runUtt(3, 2, 1'b0, 1'b0, "tie");
    check(int'(winIdx) == 1, "R8 tie keeps lower index", int'(winIdx), 1);

    // R5 / R2: forward path blocked, last state never reached
    fillConst(0, 0, 0, -32768);
    runUtt(1, 1, 1'b0, 1'b0, "blocked");
    check(int'(winScore) == -32768, "R5 last state unreachable", int'(winScore), -32768);

    // R6 upper saturation
    fillConst(0, 32767, 32767, 32767);
    runUtt(1, 1, 1'b0, 1'b0, "sat high");
    check(int'(winScore) == 32767, "R6 saturate high", int'(winScore), 32767);

    // R6 lower saturation
    fillConst(0, -20000, 0, 0);
    runUtt(1, 1, 1'b0, 1'b0, "sat low");
    check(int'(winScore) == -32768, "R6 saturate low", int'(winScore), -32768);

    // R9 end flag during the last update phase; last model must win
    fillConst(0, -900, -100, -100);
    fillConst(1, -10, -5, -5);
    runUtt(2, 2, 1'b1, 1'b0, "end during update");
    check(int'(winIdx) == 1, "R9 pending end includes last model", int'(winIdx), 1);

    // R10 a fresh utterance forgets the earlier best
    fillConst(0, 0, 0, 0);
    runUtt(1, 1, 1'b0, 1'b0, "first");
    fillConst(0, -700, -50, -50);
    runUtt(1, 1, 1'b0, 1'b0, "second");
    check(int'(winScore) == refFinal(0, M), "R10 no carry-over", int'(winScore), refFinal(0, M));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule